// File: doc/BRIEF.md
# Bus-Master Disk DMA Engine

This block moves data for one disk channel between a drive's data handshake and system memory without processor involvement. Software programs a byte-wide register window with the address of a descriptor table, selects a direction and sets a start bit. The engine then reads descriptors from memory, each naming a buffer and a byte count. It transfers 16-bit words to or from the drive until it has processed the descriptor flagged as last. Completion, faults and drive interrupts are reported in a status byte and on an interrupt output.

The engine does not issue drive commands, set transfer timing or deal with host configuration. Software normally sends the drive its command first and only then sets the start bit. The drive may therefore raise its data request before the engine is running, and the engine holds that request off until start.

Top module: `bmdma_engine`

## Requirements
- R1: After reset every readable register returns 0 and `irq` is low.
- R2: Register offsets: 0 is the command byte, with bit 0 as start and bit 3 as direction. Offsets 1 and 3 are free scratch bytes that read back what was written. Offset 2 is status. Offsets 4 to 7 hold the table pointer, least significant byte at offset 4, and pointer bits 1:0 always read 0.
- R3: Status bits 5 and 6 are plain read/write drive-capability flags. Engine events never change them.
- R4: Writing 1 to status bit 1 (error) or bit 2 (interrupt) clears that bit. Writing 0 there leaves it unchanged. Status bit 0 (active) ignores writes.
- R5: The engine never acknowledges a drive request before start is set. A request that is already pending is served once start is set. Status bit 0 rises only through a start write.
- R6: A descriptor is two little-endian 32-bit words at consecutive table addresses. The first word is the buffer address, with bit 0 ignored. The second word holds the byte count in bits CNT_W-1:0, with bit 0 ignored, and bit 31 set marks the last descriptor. Descriptors are taken in 8-byte steps. No byte beyond a descriptor's count is touched, and the walk ends after the last descriptor.
- R7: An even count of zero means 2^CNT_W bytes.
- R8: With direction 1, each 16-bit word taken from the drive is stored little-endian at ascending buffer addresses. With direction 0, memory halfwords are read and presented to the drive in order.
- R9: After the last word has moved and a rising edge has arrived on `drv_irq`, status bits 2:0 read 3'b100.
- R10: A drive interrupt that arrives before the table is finished sets status bit 2 while bit 0 stays 1. Bit 0 clears when the last word has moved.
- R11: A memory error response sets status bits 2:0 to 3'b110 and stops all further memory and drive activity.
- R12: Writing start=0 during a transfer stops memory requests and drive acknowledges at once, clears bit 0 and leaves bit 2 at 0.
- R13: `irq` always equals status bit 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register byte offset |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data for `reg_addr` |
| mem_req | output | 1 | Memory access request, held until ack or error |
| mem_we | output | 1 | 1 = write access |
| mem_hword | output | 1 | 1 = 16-bit data access, 0 = 32-bit descriptor read |
| mem_addr | output | AW | Byte address |
| mem_wdata | output | 32 | Write data, halfword in bits 15:0 |
| mem_rdata | input | 32 | Read data, valid with ack |
| mem_ack | input | 1 | Access completed |
| mem_err | input | 1 | Access failed |
| drv_dreq | input | 1 | Drive ready for a word |
| drv_dack | output | 1 | One-cycle word acknowledge to drive |
| drv_rdata | input | 16 | Word from the drive |
| drv_wdata | output | 16 | Word to the drive, valid with `drv_dack` |
| drv_irq | input | 1 | Drive interrupt level |
| irq | output | 1 | Interrupt to the host |

## Verification
The bench runs a behavioural memory and drive model and predicts every byte in memory and every word at the drive. It checks that the guard bytes next to each buffer keep their fill value, which exposes an off-by-one word count or an ignored last-descriptor flag. Further scenarios cover: a drive request pending before start, which a wrong design would serve early; a drive interrupt ahead of the data, which a wrong design would take as completion; a zero count, which a wrong design would treat as an empty descriptor; an error response from memory; and a stop mid-transfer, which a wrong design would either continue past or flag with an interrupt.

// File: rtl/bmdma_pkg.sv
package bmdma_pkg;
   localparam int WORD_W = 16;

   localparam logic [2:0] OFS_CMD  = 3'd0;
   localparam logic [2:0] OFS_SCR1 = 3'd1;
   localparam logic [2:0] OFS_STAT = 3'd2;
   localparam logic [2:0] OFS_SCR3 = 3'd3;

   typedef enum logic [2:0] {
      WK_IDLE,
      WK_DESC_ADDR,
      WK_DESC_CNT,
      WK_DRV_WAIT,
      WK_DRV_ACK,
      WK_MEM_RD,
      WK_MEM_WR,
      WK_TAIL
   } walk_state_t;
endpackage

// File: rtl/bmdma_regs.sv
module bmdma_regs
   import bmdma_pkg::*;
(
   input  logic        clk,
   input  logic        rst_n,
   input  logic        wr_en,
   input  logic [2:0]  addr,
   input  logic [7:0]  wdata,
   output logic [7:0]  rdata,
   input  logic        irq_rise,
   input  logic        ev_finish,
   input  logic        ev_err,
   output logic        run,
   output logic        dir,
   output logic        go,
   output logic        active,
   output logic        intr,
   output logic [31:0] tbl_ptr
);
   logic       err;
   logic [1:0] cap;
   logic [7:0] scr1, scr3;
   logic       wr_cmd, wr_stat, stop;

   assign wr_cmd  = wr_en && (addr == OFS_CMD);
   assign wr_stat = wr_en && (addr == OFS_STAT);
   assign go      = wr_cmd && wdata[0] && !run;
   assign stop    = wr_cmd && !wdata[0] && run;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         run <= 1'b0; dir <= 1'b0; active <= 1'b0; err <= 1'b0; intr <= 1'b0;
         cap <= '0; scr1 <= '0; scr3 <= '0; tbl_ptr <= '0;
      end else begin
         if (wr_cmd) begin
            run <= wdata[0];
            if (!run) dir <= wdata[3];
         end
         if (go)                                active <= 1'b1;
         else if (ev_finish || ev_err || stop)  active <= 1'b0;
         if (ev_err)                            err <= 1'b1;
         else if (wr_stat && wdata[1])          err <= 1'b0;
         if (ev_err || (irq_rise && active))    intr <= 1'b1;
         else if (wr_stat && wdata[2])          intr <= 1'b0;
         if (wr_stat) cap <= wdata[6:5];
         if (wr_en && addr == OFS_SCR1) scr1 <= wdata;
         if (wr_en && addr == OFS_SCR3) scr3 <= wdata;
         if (wr_en && addr[2]) begin
            case (addr[1:0])
               2'd0: tbl_ptr[7:0]   <= {wdata[7:2], 2'b00};
               2'd1: tbl_ptr[15:8]  <= wdata;
               2'd2: tbl_ptr[23:16] <= wdata;
               default: tbl_ptr[31:24] <= wdata;
            endcase
         end
      end
   end

   always_comb begin
      case (addr)
         OFS_CMD:  rdata = {4'b0, dir, 2'b0, run};
         OFS_SCR1: rdata = scr1;
         OFS_STAT: rdata = {1'b0, cap, 2'b0, intr, err, active};
         OFS_SCR3: rdata = scr3;
         3'd4:     rdata = tbl_ptr[7:0];
         3'd5:     rdata = tbl_ptr[15:8];
         3'd6:     rdata = tbl_ptr[23:16];
         default:  rdata = tbl_ptr[31:24];
      endcase
   end

   // R5: the active flag only rises through a start write
   p_active_rise_r5: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(active) |-> $past(go));
   // R3: capability flags move only on a status write
   p_cap_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_stat |=> $stable(cap));
endmodule

// File: rtl/bmdma_walker.sv
module bmdma_walker
   import bmdma_pkg::*;
#(
   parameter int AW    = 32,
   parameter int CNT_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              go,
   input  logic              run,
   input  logic              dir,
   input  logic [AW-1:0]     tbl_ptr,
   input  logic              irq_rise,
   output logic              mem_req,
   output logic              mem_we,
   output logic              mem_hword,
   output logic [AW-1:0]     mem_addr,
   output logic [31:0]       mem_wdata,
   input  logic [31:0]       mem_rdata,
   input  logic              mem_ack,
   input  logic              mem_err,
   input  logic              drv_dreq,
   output logic              drv_dack,
   input  logic [WORD_W-1:0] drv_rdata,
   output logic [WORD_W-1:0] drv_wdata,
   output logic              ev_finish,
   output logic              ev_err
);
   localparam int             REM_W    = CNT_W + 1;
   localparam logic [REM_W-1:0] FULL_CNT = {1'b1, {CNT_W{1'b0}}};
   localparam logic [REM_W-1:0] STEP     = REM_W'(WORD_W / 8);

   walk_state_t       st;
   logic [AW-1:0]     ptr, cur;
   logic [REM_W-1:0]  rem;
   logic              last_desc, irq_seen;
   logic [WORD_W-1:0] dbuf;
   logic [CNT_W-1:0]  cnt_even;
   walk_state_t       after_word;

   generate
      if (CNT_W < 2 || CNT_W > 16 || AW < CNT_W + 1 || AW > 32) begin : g_bad_cfg
         $error("bmdma_walker: CNT_W must be 2..16 and AW in CNT_W+1..32");
      end
   endgenerate

   assign cnt_even = {mem_rdata[CNT_W-1:1], 1'b0};

   always_comb begin
      if (rem == STEP)
         after_word = last_desc ? WK_TAIL : WK_DESC_ADDR;
      else
         after_word = dir ? WK_DRV_WAIT : WK_MEM_RD;
   end

   assign mem_req   = run && (st == WK_DESC_ADDR || st == WK_DESC_CNT ||
                              st == WK_MEM_RD || st == WK_MEM_WR);
   assign mem_we    = (st == WK_MEM_WR);
   assign mem_hword = (st == WK_MEM_RD || st == WK_MEM_WR);
   assign mem_addr  = (st == WK_DESC_ADDR) ? ptr :
                      (st == WK_DESC_CNT)  ? ptr + AW'(4) : cur;
   assign mem_wdata = {{(32-WORD_W){1'b0}}, dbuf};
   assign drv_dack  = run && (st == WK_DRV_ACK);
   assign drv_wdata = dbuf;
   assign ev_err    = mem_req && mem_err;
   assign ev_finish = run && (st == WK_TAIL) && (irq_seen || irq_rise);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st <= WK_IDLE; ptr <= '0; cur <= '0; rem <= '0;
         last_desc <= 1'b0; irq_seen <= 1'b0; dbuf <= '0;
      end else if (go) begin
         st <= WK_DESC_ADDR; ptr <= tbl_ptr; irq_seen <= 1'b0;
      end else if (st != WK_IDLE && !run) begin
         st <= WK_IDLE;
      end else begin
         if (irq_rise && st != WK_IDLE) irq_seen <= 1'b1;
         if (ev_err) st <= WK_IDLE;
         else begin
            unique case (st)
               WK_DESC_ADDR: if (mem_ack) begin
                  cur <= {mem_rdata[AW-1:1], 1'b0};
                  st  <= WK_DESC_CNT;
               end
               WK_DESC_CNT: if (mem_ack) begin
                  rem       <= (cnt_even == '0) ? FULL_CNT : {1'b0, cnt_even};
                  last_desc <= mem_rdata[31];
                  ptr       <= ptr + AW'(8);
                  st        <= dir ? WK_DRV_WAIT : WK_MEM_RD;
               end
               WK_MEM_RD: if (mem_ack) begin
                  dbuf <= mem_rdata[WORD_W-1:0];
                  st   <= WK_DRV_WAIT;
               end
               WK_DRV_WAIT: if (drv_dreq) begin
                  if (dir) dbuf <= drv_rdata;
                  st <= WK_DRV_ACK;
               end
               WK_DRV_ACK: begin
                  if (dir) st <= WK_MEM_WR;
                  else begin
                     cur <= cur + AW'(2); rem <= rem - STEP; st <= after_word;
                  end
               end
               WK_MEM_WR: if (mem_ack) begin
                  cur <= cur + AW'(2); rem <= rem - STEP; st <= after_word;
               end
               WK_TAIL: if (irq_seen || irq_rise) st <= WK_IDLE;
               default: ;
            endcase
         end
      end
   end

   // R6: a memory request holds its address until answered
   p_req_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req && !mem_ack && !mem_err && run |=> mem_req && $stable(mem_addr));
   // R11: an error response ends memory activity
   p_err_halts_r11: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req && mem_err |=> !mem_req);
endmodule

// File: rtl/bmdma_engine.sv
module bmdma_engine
   import bmdma_pkg::*;
#(
   parameter int AW    = 32,
   parameter int CNT_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_wr,
   input  logic [2:0]        reg_addr,
   input  logic [7:0]        reg_wdata,
   output logic [7:0]        reg_rdata,
   output logic              mem_req,
   output logic              mem_we,
   output logic              mem_hword,
   output logic [AW-1:0]     mem_addr,
   output logic [31:0]       mem_wdata,
   input  logic [31:0]       mem_rdata,
   input  logic              mem_ack,
   input  logic              mem_err,
   input  logic              drv_dreq,
   output logic              drv_dack,
   input  logic [WORD_W-1:0] drv_rdata,
   output logic [WORD_W-1:0] drv_wdata,
   input  logic              drv_irq,
   output logic              irq
);
   logic        irq_q, irq_rise;
   logic        run, dir, go, active, intr, ev_finish, ev_err;
   logic [31:0] tbl_ptr;

   always_ff @(posedge clk) begin
      if (!rst_n) irq_q <= 1'b0;
      else        irq_q <= drv_irq;
   end
   assign irq_rise = drv_irq && !irq_q;
   assign irq      = intr;

   bmdma_regs u_regs (
      .clk(clk), .rst_n(rst_n), .wr_en(reg_wr), .addr(reg_addr),
      .wdata(reg_wdata), .rdata(reg_rdata), .irq_rise(irq_rise),
      .ev_finish(ev_finish), .ev_err(ev_err), .run(run), .dir(dir), .go(go),
      .active(active), .intr(intr), .tbl_ptr(tbl_ptr)
   );

   bmdma_walker #(.AW(AW), .CNT_W(CNT_W)) u_walk (
      .clk(clk), .rst_n(rst_n), .go(go), .run(run), .dir(dir),
      .tbl_ptr(tbl_ptr[AW-1:0]), .irq_rise(irq_rise),
      .mem_req(mem_req), .mem_we(mem_we), .mem_hword(mem_hword),
      .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
      .mem_ack(mem_ack), .mem_err(mem_err), .drv_dreq(drv_dreq),
      .drv_dack(drv_dack), .drv_rdata(drv_rdata), .drv_wdata(drv_wdata),
      .ev_finish(ev_finish), .ev_err(ev_err)
   );

   // R5: no drive acknowledge unless the engine is active
   p_dack_active_r5: assert property (@(posedge clk) disable iff (!rst_n)
      drv_dack |-> active);
endmodule

// File: tb/bmdma_engine_test.sv
module bmdma_engine_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        reg_wr = 1'b0;
   logic [2:0]  reg_addr = '0;
   logic [7:0]  reg_wdata = '0;
   logic [7:0]  reg_rdata;
   logic        mem_req, mem_we, mem_hword;
   logic [31:0] mem_addr, mem_wdata;
   logic [31:0] mem_rdata = '0;
   logic        mem_ack = 1'b0, mem_err = 1'b0;
   logic        drv_dreq = 1'b0, drv_dack, drv_irq = 1'b0, irq;
   logic [15:0] drv_rdata = '0, drv_wdata;

   int n_chk = 0, n_err = 0, cyc = 0;
   logic [7:0]  mem_b [0:4095];
   logic [15:0] rd_q[$];
   logic [15:0] got_q[$];
   logic        drv_en = 1'b0, drv_dir = 1'b0, started = 1'b0;
   logic        err_on = 1'b0;
   logic [31:0] err_addr = '0;

   always #4 clk = ~clk;

   bmdma_engine #(.AW(32), .CNT_W(8)) uut (
      .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mem_req(mem_req),
      .mem_we(mem_we), .mem_hword(mem_hword), .mem_addr(mem_addr),
      .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_ack(mem_ack),
      .mem_err(mem_err), .drv_dreq(drv_dreq), .drv_dack(drv_dack),
      .drv_rdata(drv_rdata), .drv_wdata(drv_wdata), .drv_irq(drv_irq), .irq(irq)
   );

   task automatic chk(input string rq, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s: actual=%h expected=%h", rq, act, exp);
      end
   endtask

   // memory model: one-cycle response, optional error at one address
   always @(negedge clk) begin
      if (mem_ack || mem_err) begin
         mem_ack = 1'b0; mem_err = 1'b0;
      end else if (mem_req) begin
         if (err_on && mem_addr == err_addr) mem_err = 1'b1;
         else begin
            if (mem_we) begin
               mem_b[mem_addr[11:0]]       = mem_wdata[7:0];
               mem_b[mem_addr[11:0] + 12'd1] = mem_wdata[15:8];
            end
            mem_rdata = {mem_b[mem_addr[11:0] + 12'd3], mem_b[mem_addr[11:0] + 12'd2],
                         mem_b[mem_addr[11:0] + 12'd1], mem_b[mem_addr[11:0]]};
            mem_ack = 1'b1;
         end
      end
   end

   // drive model and per-cycle monitor
   always @(negedge clk) begin
      if (rst_n && !started) begin
         n_chk++;
         if (drv_dack) begin
            n_err++;
            $display("FAIL R5: actual dack=1 expected dack=0 while not started");
         end
      end
      if (drv_dack) begin
         if (drv_dir) void'(rd_q.pop_front());
         else got_q.push_back(drv_wdata);
      end
      drv_rdata = (rd_q.size() > 0) ? rd_q[0] : 16'h0;
      drv_dreq  = drv_en && (drv_dir ? (rd_q.size() > 0) : 1'b1);
   end

   always @(posedge clk) begin
      cyc++;
      if (cyc > 150000) begin
         n_err++; n_chk++;
         $display("FAIL R9: watchdog expired actual=running expected=done");
         $display("Result: errors=%0d of %0d checks", n_err, n_chk);
         $finish;
      end
   end

   task automatic wr(input logic [2:0] a, input logic [7:0] d);
      @(negedge clk); reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
      @(negedge clk); reg_wr = 1'b0; #1;
   endtask

   task automatic rd(input logic [2:0] a, output logic [7:0] d);
      @(negedge clk); reg_addr = a; #1; d = reg_rdata;
   endtask

   task automatic put32(input int a, input logic [31:0] v);
      for (int i = 0; i < 4; i++) mem_b[a + i] = v[8*i +: 8];
   endtask

   task automatic set_ptr(input logic [31:0] p);
      for (int i = 0; i < 4; i++) wr(3'(4 + i), p[8*i +: 8]);
   endtask

   task automatic pulse_irq;
      @(negedge clk); drv_irq = 1'b1;
      repeat (3) @(negedge clk);
      drv_irq = 1'b0; #1;
   endtask

   task automatic stop_eng(input logic [7:0] c);
      wr(3'd0, c); started = 1'b0;
   endtask

   logic [7:0] v;
   int         keep;

   initial begin
      for (int i = 0; i < 4096; i++) mem_b[i] = 8'hEE;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      // R1: reset state
      for (int i = 0; i < 8; i++) begin
         rd(3'(i), v); chk("R1 reg after reset", v, 0);
      end
      chk("R1 irq after reset", irq, 0);

      // R2: register map
      wr(3'd1, 8'hA5); wr(3'd3, 8'h3C);
      rd(3'd1, v); chk("R2 scratch1", v, 8'hA5);
      rd(3'd3, v); chk("R2 scratch3", v, 8'h3C);
      set_ptr(32'h0000_0103);
      rd(3'd4, v); chk("R2 ptr low bits zero", v, 8'h00);
      rd(3'd5, v); chk("R2 ptr byte1", v, 8'h01);
      // R3 / R4: flags read/write, active bit ignores writes
      wr(3'd2, 8'h61); rd(3'd2, v); chk("R3 R4 status flags", v, 8'h60);
      wr(3'd2, 8'h20); rd(3'd2, v); chk("R3 status flag5 only", v, 8'h20);
      wr(3'd2, 8'h60);

      // R5 R6 R8 R9: drive to memory, two descriptors, request before start
      put32(32'h100, 32'h400); put32(32'h104, 32'h6);
      put32(32'h108, 32'h500); put32(32'h10C, 32'h8000_0004);
      for (int k = 0; k < 5; k++) rd_q.push_back(16'hA000 + 16'(k));
      drv_dir = 1'b1; drv_en = 1'b1;
      set_ptr(32'h100);
      repeat (10) @(negedge clk);
      chk("R5 no transfer before start", rd_q.size(), 5);
      started = 1'b1; wr(3'd0, 8'h09);
      repeat (100) @(negedge clk);
      chk("R5 pending request served", rd_q.size(), 0);
      rd(3'd2, v); chk("R9 active until drive irq", v, 8'h61);
      rd(3'd0, v); chk("R2 command readback", v, 8'h09);
      pulse_irq;
      rd(3'd2, v); chk("R9 success status", v, 8'h64);
      chk("R13 irq high", irq, 1);
      for (int k = 0; k < 3; k++) begin
         chk("R8 desc0 word", {mem_b[32'h401 + 2*k], mem_b[32'h400 + 2*k]}, 16'hA000 + 16'(k));
      end
      for (int k = 0; k < 2; k++) begin
         chk("R8 desc1 word", {mem_b[32'h501 + 2*k], mem_b[32'h500 + 2*k]}, 16'hA003 + 16'(k));
      end
      chk("R6 guard after desc0", mem_b[32'h406], 8'hEE);
      chk("R6 guard after desc1", mem_b[32'h504], 8'hEE);
      wr(3'd2, 8'h60); rd(3'd2, v); chk("R4 write 0 keeps intr", v, 8'h64);
      wr(3'd2, 8'h64); rd(3'd2, v); chk("R4 W1C intr", v, 8'h60);
      chk("R13 irq low", irq, 0);
      stop_eng(8'h00);

      // R8 R10: memory to drive, drive interrupts early
      for (int k = 0; k < 4; k++) begin
         mem_b[32'h600 + 2*k] = 8'(8'h10 + k); mem_b[32'h601 + 2*k] = 8'h33;
      end
      put32(32'h180, 32'h600); put32(32'h184, 32'h8000_0008);
      drv_en = 1'b0; drv_dir = 1'b0;
      set_ptr(32'h180);
      started = 1'b1; wr(3'd0, 8'h01);
      repeat (10) @(negedge clk);
      pulse_irq;
      rd(3'd2, v); chk("R10 intr with active", v, 8'h65);
      drv_en = 1'b1;
      repeat (60) @(negedge clk);
      rd(3'd2, v); chk("R10 active cleared at end", v, 8'h64);
      chk("R8 word count to drive", got_q.size(), 4);
      for (int k = 0; k < 4; k++) begin
         if (k < got_q.size()) chk("R8 word to drive", got_q[k], 16'h3310 + 16'(k));
      end
      wr(3'd2, 8'h64); stop_eng(8'h00);

      // R7: count zero means 2^CNT_W bytes
      put32(32'h1A0, 32'h800); put32(32'h1A4, 32'h8000_0000);
      for (int k = 0; k < 128; k++) rd_q.push_back(16'h5000 + 16'(k));
      drv_dir = 1'b1;
      set_ptr(32'h1A0);
      started = 1'b1; wr(3'd0, 8'h08 | 8'h01);
      repeat (1200) @(negedge clk);
      pulse_irq;
      rd(3'd2, v); chk("R7 full-size status", v, 8'h64);
      keep = 0;
      for (int k = 0; k < 128; k++) begin
         if ({mem_b[32'h801 + 2*k], mem_b[32'h800 + 2*k]} !== 16'h5000 + 16'(k)) keep++;
      end
      chk("R7 words mismatching", keep, 0);
      chk("R7 guard after full block", mem_b[32'h900], 8'hEE);
      wr(3'd2, 8'h64); stop_eng(8'h00);

      // R11: memory error response
      put32(32'h1C0, 32'hA00); put32(32'h1C4, 32'h8000_0010);
      for (int k = 0; k < 8; k++) rd_q.push_back(16'h7700 + 16'(k));
      err_on = 1'b1; err_addr = 32'hA04;
      set_ptr(32'h1C0);
      started = 1'b1; wr(3'd0, 8'h09);
      repeat (60) @(negedge clk);
      rd(3'd2, v); chk("R11 error status", v, 8'h66);
      chk("R11 words taken before error", rd_q.size(), 5);
      chk("R11 failed address untouched", mem_b[32'hA04], 8'hEE);
      chk("R11 first word stored", {mem_b[32'hA01], mem_b[32'hA00]}, 16'h7700);
      repeat (20) @(negedge clk);
      chk("R11 no activity after error", rd_q.size(), 5);
      wr(3'd2, 8'h66); rd(3'd2, v); chk("R4 W1C both", v, 8'h60);
      err_on = 1'b0; stop_eng(8'h00);
      rd_q.delete();

      // R12: stop mid-transfer
      put32(32'h1E0, 32'hC00); put32(32'h1E4, 32'h8000_0020);
      for (int k = 0; k < 16; k++) rd_q.push_back(16'h9900 + 16'(k));
      set_ptr(32'h1E0);
      started = 1'b1; wr(3'd0, 8'h09);
      for (int t = 0; t < 200 && rd_q.size() > 12; t++) @(negedge clk);
      stop_eng(8'h08);
      keep = rd_q.size();
      repeat (20) @(negedge clk);
      chk("R12 no acknowledge after stop", rd_q.size(), keep);
      rd(3'd2, v); chk("R12 status after stop", v, 8'h60);
      chk("R12 irq stays low", irq, 0);
      chk("R3 flags survived all events", v[6:5], 2'b11);

      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end
endmodule